// File: doc/BRIEF.md
# SPI Serial Clock Divider with Mantissa-Exponent Prescale

This block derives the serial clock of an SPI controller from the core clock. An 8-bit prescale field sets the divisor. A parameter picks one of two ways to read that field. The first is a legacy code that gives even divisors from 4 to 30. The second is an extended code in which the divisor is a 4-bit mantissa shifted left by a 3-bit exponent. The exponent bits are not contiguous in the field.

Besides the clock level, the divider emits two single-cycle strobes. A sample strobe marks every leading edge, which is the edge leaving the idle level. A launch strobe marks every trailing edge, which is the edge returning to idle. The shift logic of the controller uses these strobes to move data. While the enable is low, the clock rests at the idle level that the CPOL input selects.

Top module: `spi_sck_divider`

## Requirements
- R1: With EXT_ENC=1 the divisor is SPR << SPPR. SPR is prescale[3:0]. SPPR is {prescale[7], prescale[6], prescale[4]}, with prescale[4] as the least significant bit. One SCK period lasts exactly that many core cycles.
- R2: With EXT_ENC=1, prescale[5] has no effect on the divisor, and an SPR of 0 acts as an SPR of 1.
- R3: With EXT_ENC=1, any divisor that works out below 2 is raised to 2.
- R4: With EXT_ENC=0 the divisor is twice prescale[3:0]. A value of prescale[3:0] below 2 gives a divisor of 4. Bits 7:4 have no effect.
- R5: The level SCK takes opposite to CPOL lasts floor(div/2) cycles when CPOL=0 and ceil(div/2) cycles when CPOL=1. As a result, for an odd divisor the high half-period is one cycle shorter than the low half-period.
- R6: During reset, and from the first clock edge at which en is sampled low, sck equals CPOL and both strobes stay low.
- R7: `sample` is high exactly in the cycles where sck first shows the level opposite to CPOL. `launch` is high exactly in the cycles where sck first returns to CPOL. There is one of each per period, and they are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run the divider; low forces the idle level |
| cpol | input | 1 | Idle level of the serial clock |
| prescale | input | 8 | Divisor code, read as set by EXT_ENC |
| sck | output | 1 | Serial clock level |
| launch | output | 1 | One-cycle strobe at each trailing SCK edge |
| sample | output | 1 | One-cycle strobe at each leading SCK edge |

## Verification
The bench builds the block twice, side by side. One instance has EXT_ENC=1 and the other has EXT_ENC=0, and both share the same inputs. This lets a single vector table cover both encodings. The extended instance covers the following cases:
- the zero-mantissa and below-two clamps;
- the ignored bit 5;
- every exponent bit position;
- odd divisors with both CPOL values;
- the largest divisor, 1920.

The legacy instance covers the low clamp, the top divisor of 30 and the bits that are ignored.

// File: rtl/spi_clkdiv_pkg.sv
package spi_clkdiv_pkg;

    localparam int PS_W   = 8;
    localparam int SPR_W  = 4;
    localparam int SPPR_W = 3;
    localparam int DIV_W  = SPR_W + (1 << SPPR_W) - 1 + 1;

    typedef logic [DIV_W-1:0] div_t;

    typedef struct packed {
        logic [SPR_W-1:0]  spr;
        logic [SPPR_W-1:0] sppr;
    } mant_exp_t;

    typedef struct packed {
        div_t period;
        div_t idle_len;
    } ratio_t;

    // Mantissa-exponent divisor; zero mantissa acts as one, result at least two.
    function automatic div_t ext_divisor(input mant_exp_t f);
        logic [SPR_W-1:0] m;
        div_t d;
        m = (f.spr == '0) ? SPR_W'(1) : f.spr;
        d = div_t'(m) << f.sppr;
        if (d < div_t'(2)) d = div_t'(2);
        return d;
    endfunction

    // Legacy code: twice the low nibble, minimum four.
    function automatic div_t leg_divisor(input logic [3:0] n);
        logic [3:0] h;
        h = (n < 4'd2) ? 4'd2 : n;
        return div_t'({h, 1'b0});
    endfunction

    // Cycles spent at the idle level in each period.
    function automatic div_t idle_span(input div_t d, input logic pol);
        return pol ? (d >> 1) : div_t'((d + div_t'(1)) >> 1);
    endfunction

endpackage

// File: rtl/spi_clkdiv_decode.sv
module spi_clkdiv_decode
    import spi_clkdiv_pkg::*;
#(
    parameter bit EXT_ENC = 1'b1
) (
    input  logic [PS_W-1:0] prescale,
    input  logic            cpol,
    output ratio_t          ratio
);

    div_t period;

    generate
        if (EXT_ENC) begin : g_ext
            mant_exp_t field;
            logic      unused_gap;
            assign field.spr  = prescale[3:0];
            assign field.sppr = {prescale[7:6], prescale[4]};
            assign unused_gap = prescale[5];
            assign period     = ext_divisor(field);
        end else begin : g_leg
            logic [3:0] unused_hi;
            assign unused_hi = prescale[7:4];
            assign period    = leg_divisor(prescale[3:0]);
        end
    endgenerate

    assign ratio.period   = period;
    assign ratio.idle_len = idle_span(period, cpol);

endmodule

// File: rtl/spi_clkdiv_count.sv
module spi_clkdiv_count
    import spi_clkdiv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  div_t period,
    output div_t cnt_next,
    output logic wrap
);

    div_t cnt_q;

    assign wrap     = (cnt_q >= period - div_t'(1));
    assign cnt_next = wrap ? '0 : cnt_q + div_t'(1);

    always_ff @(posedge clk) begin
        if (rst || !en) cnt_q <= '0;
        else            cnt_q <= cnt_next;
    end

    // R1: the phase counter stays inside the period once the divisor holds still
    a_r1_count_bound: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && $stable(period)) |-> (cnt_q < period));

endmodule

// File: rtl/spi_sck_divider.sv
module spi_sck_divider
    import spi_clkdiv_pkg::*;
#(
    parameter bit EXT_ENC = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            cpol,
    input  logic [PS_W-1:0] prescale,
    output logic            sck,
    output logic            launch,
    output logic            sample
);

    ratio_t ratio;
    div_t   cnt_next;
    logic   wrap;

    spi_clkdiv_decode #(.EXT_ENC(EXT_ENC)) u_decode (
        .prescale (prescale),
        .cpol     (cpol),
        .ratio    (ratio)
    );

    spi_clkdiv_count u_count (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .period   (ratio.period),
        .cnt_next (cnt_next),
        .wrap     (wrap)
    );

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            sck    <= cpol;
            sample <= 1'b0;
            launch <= 1'b0;
        end else begin
            sck    <= cpol ^ (cnt_next >= ratio.idle_len);
            sample <= (cnt_next == ratio.idle_len);
            launch <= wrap;
        end
    end

    // R6: disabled means idle level and quiet strobes on the next cycle
    a_r6_idle_when_off: assert property (@(posedge clk) disable iff (rst)
        !en |=> (sck == $past(cpol)) && !sample && !launch);

    // R7: the two strobes never coincide
    a_r7_strobes_apart: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sample, launch}));

    // R7: a sample strobe always accompanies a change of SCK level
    a_r7_sample_on_edge: assert property (@(posedge clk) disable iff (rst)
        (sample && $past(en) && $stable(cpol)) |-> (sck != $past(sck)));

    // R7: a launch strobe always accompanies a return to idle
    a_r7_launch_on_edge: assert property (@(posedge clk) disable iff (rst)
        (launch && $stable(cpol)) |-> (sck != $past(sck)) && (sck == cpol));

endmodule

// File: tb/tb_spi_sck_divider.sv
module tb_spi_sck_divider;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic       cpol = 1'b0;
    logic [7:0] prescale = 8'h00;
    logic       sck_e, launch_e, sample_e;
    logic       sck_l, launch_l, sample_l;
    logic       use_leg = 1'b0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    spi_sck_divider #(.EXT_ENC(1'b1)) dut (
        .clk(clk), .rst(rst), .en(en), .cpol(cpol), .prescale(prescale),
        .sck(sck_e), .launch(launch_e), .sample(sample_e)
    );

    spi_sck_divider #(.EXT_ENC(1'b0)) dut_leg (
        .clk(clk), .rst(rst), .en(en), .cpol(cpol), .prescale(prescale),
        .sck(sck_l), .launch(launch_l), .sample(sample_l)
    );

    wire sck_s = use_leg ? sck_l    : sck_e;
    wire lch_s = use_leg ? launch_l : launch_e;
    wire smp_s = use_leg ? sample_l : sample_e;

    // {legacy, prescale, cpol, expected divisor}
    localparam int NV = 15;
    localparam logic [21:0] VEC [NV] = '{
        {1'b0, 8'h05, 1'b0, 12'd5},
        {1'b0, 8'h13, 1'b0, 12'd6},
        {1'b0, 8'h43, 1'b1, 12'd12},
        {1'b0, 8'h33, 1'b0, 12'd6},
        {1'b0, 8'h00, 1'b0, 12'd2},
        {1'b0, 8'h01, 1'b1, 12'd2},
        {1'b0, 8'h8F, 1'b0, 12'd240},
        {1'b0, 8'hDF, 1'b1, 12'd1920},
        {1'b0, 8'h07, 1'b1, 12'd7},
        {1'b1, 8'h12, 1'b0, 12'd4},
        {1'b1, 8'h1F, 1'b1, 12'd30},
        {1'b1, 8'h15, 1'b0, 12'd10},
        {1'b1, 8'h0F, 1'b0, 12'd30},
        {1'b1, 8'h10, 1'b1, 12'd4},
        {1'b1, 8'hE3, 1'b0, 12'd6}
    };

    function automatic string req_of(input int i);
        case (i)
            3:       return "R2";
            4, 5:    return "R3";
            default: return (i >= 9) ? "R4" : "R1";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic run_vec(input int i);
        logic        leg, pol, s, prev;
        logic [7:0]  ps;
        int          div, exp_act, leads, t2, t3, act, bad;
        {leg, ps, pol} = VEC[i][21:12];
        div = int'(VEC[i][11:0]);
        exp_act = pol ? (div + 1) / 2 : div / 2;
        en = 1'b0; use_leg = leg; prescale = ps; cpol = pol;
        repeat (3) @(negedge clk);
        en = 1'b1;
        leads = 0; t2 = 0; t3 = 0; act = 0; bad = 0;
        prev = sck_s;
        for (int c = 0; c < 4 * div + 8 && leads < 3; c++) begin
            @(negedge clk);
            s = sck_s;
            if (smp_s != ((s != prev) && (s != pol))) bad++;
            if (lch_s != ((s != prev) && (s == pol))) bad++;
            if (smp_s) begin
                leads++;
                if (leads == 2) t2 = c;
                if (leads == 3) t3 = c;
            end
            if (leads == 2 && s != pol) act++;
            prev = s;
        end
        check(t3 - t2 == div, req_of(i), t3 - t2, div);
        check(act == exp_act, "R5", act, exp_act);
        check(bad == 0 && leads == 3, "R7", bad, 0);
        en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        int quiet;
        repeat (3) @(negedge clk);
        check(sck_e == 1'b0 && sample_e == 1'b0 && launch_e == 1'b0, "R6", int'(sck_e), 0);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NV; i++) run_vec(i);

        // disabled: SCK follows CPOL, strobes quiet
        en = 1'b0; cpol = 1'b1; prescale = 8'h01;
        repeat (2) @(negedge clk);
        check(sck_e == 1'b1 && sck_l == 1'b1, "R6", int'(sck_e), 1);
        quiet = 0;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (sample_e || launch_e || sample_l || launch_l || !sck_e) quiet++;
        end
        check(quiet == 0, "R6", quiet, 0);

        // drop enable while SCK sits at its active level
        use_leg = 1'b0; cpol = 1'b0; prescale = 8'h8F;
        @(negedge clk);
        en = 1'b1;
        repeat (150) @(negedge clk);
        check(sck_e == 1'b1, "R5", int'(sck_e), 1);
        en = 1'b0;
        @(negedge clk);
        check(sck_e == 1'b0 && !sample_e && !launch_e, "R6", int'(sck_e), 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule